// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block is the combinational operand shifter that sits in front of the ALU of a 32-bit data-processing datapath. It produces the second ALU operand in one of three ways. The first is a register value shifted by an amount coded in the instruction. The second is a register value shifted by an amount held in another register. The third is a small 8-bit constant rotated right by an even amount.

Alongside the operand it produces a shifter carry-out. The ALU uses this carry as the C flag when it runs a logical operation. An amount of zero in the instruction takes on a special meaning for each shift kind, including a one-bit rotate through the carry flag. Register amounts of 32 and above also have their own fixed results. The block has no clock and no state. ALU operations and flag writeback belong to the neighbouring logic.

Top module: `bsh_operand_shifter`

## Requirements
- R1: `form_i` selects the operand form: 0 = register shifted by `imm_amt_i`, 1 = register shifted by `reg_amt_i`, 2 and 3 = rotated 8-bit immediate. `kind_i` selects the shift kind: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a nonzero amount n below 32, the result is the usual shift of `opnd_i`. The carry-out is the last bit shifted out: `opnd_i[32-n]` for a left shift and `opnd_i[n-1]` for a right shift or a rotate.
- R2: A form-0 logical left shift with amount 0 returns `opnd_i` unchanged, and the carry-out equals `carry_i`.
- R3: A form-0 logical right shift with amount 0 acts as a shift by 32. The result is 0 and the carry-out is `opnd_i[31]`.
- R4: A form-0 arithmetic right shift with amount 0 acts as a shift by 32. Every result bit and the carry-out equal `opnd_i[31]`.
- R5: A form-0 rotate with amount 0 is a one-bit rotate through carry. The result is `{carry_i, opnd_i[31:1]}` and the carry-out is `opnd_i[0]`.
- R6: Form 1 uses only `reg_amt_i[7:0]`. An amount of 0 returns `opnd_i` unchanged with the carry-out equal to `carry_i`, whatever the shift kind.
- R7: A form-1 left shift by exactly 32 gives 0 with carry-out `opnd_i[0]`. A left shift by more than 32 gives 0 with carry-out 0.
- R8: A form-1 logical right shift by exactly 32 gives 0 with carry-out `opnd_i[31]`. A logical right shift by more than 32 gives 0 with carry-out 0.
- R9: A form-1 arithmetic right shift by 32 or more fills every result bit with `opnd_i[31]` and sets the carry-out to `opnd_i[31]`.
- R10: A form-1 rotate uses the amount modulo 32. A nonzero multiple of 32 returns `opnd_i` unchanged with carry-out `opnd_i[31]`.
- R11: In forms 2 and 3 the result is `imm8_i`, zero-extended and rotated right by twice `rot_i`. The carry-out is result bit 31 when `rot_i` is nonzero, and `carry_i` otherwise.
- R12: Inputs that the selected form does not use have no effect on either output. In form 0 these are `reg_amt_i`, `rot_i` and `imm8_i`. In form 1 they are `imm_amt_i`, `rot_i` and `imm8_i`. In forms 2 and 3 they are `opnd_i`, `kind_i`, `imm_amt_i` and `reg_amt_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Register operand to be shifted |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate |
| form_i | input | 2 | Operand form: 0 immediate amount, 1 register amount, 2/3 rotated immediate |
| imm_amt_i | input | 5 | Shift amount coded in the instruction |
| reg_amt_i | input | 32 | Register holding the shift amount (low 8 bits used) |
| rot_i | input | 4 | Rotate field; the rotation is twice this value |
| imm8_i | input | 8 | 8-bit immediate for the rotated-immediate form |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, an 8-bit register amount, an 8-bit immediate and a 4-bit rotate field. With an 8-bit amount, every register amount from 0 to 255 can be reached. This covers exactly 32, the values just above 32, the multiples of 32 that rotate back to the start, and the largest amount. With a 5-bit immediate amount, every zero-amount special case of the four shift kinds is reached, along with the whole range from 1 to 31. Two sweeps over that range check the carry taken from bit 32-n and from bit n-1.

// File: rtl/bsh_pkg.sv
// Package: shared encodings for the operand barrel shifter.
// Assumes: two-bit codes for both the shift kind and the operand form.
package bsh_pkg;

    // Shift kind carried by the instruction.
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    // Operand form; bit 1 set selects the rotated immediate.
    typedef enum logic [1:0] {
        FORM_IMM_AMT = 2'd0,
        FORM_REG_AMT = 2'd1,
        FORM_ROT_IMM = 2'd2,
        FORM_ROT_ALT = 2'd3
    } operand_form_e;

endpackage

// File: rtl/bsh_rotator.sv
// Module: logarithmic right rotator.
// Rotates d right by amt using one mux stage per amount bit.
// Assumes: W is a power of two.
module bsh_rotator #(
    parameter int W = 32,
    localparam int LOG_W = $clog2(W)
) (
    input  logic [W-1:0]     d,
    input  logic [LOG_W-1:0] amt,
    output logic [W-1:0]     q
);

    logic [W-1:0] stg [0:LOG_W];

    assign stg[0] = d;

    genvar k;
    generate
        for (k = 0; k < LOG_W; k++) begin : g_stage
            localparam int STEP = 1 << k;
            // Stage k: rotate by 2**k when amount bit k is set.
            assign stg[k+1] = amt[k] ? {stg[k][STEP-1:0], stg[k][W-1:STEP]} : stg[k];
        end
    endgenerate

    assign q = stg[LOG_W];

endmodule

// File: rtl/bsh_amount_decode.sv
// Module: shift-amount normaliser.
// Turns the instruction amount or the register amount into one effective count,
// and flags the two special cases that bypass the shift core:
// pass-through (amount zero, carry unchanged) and rotate-through-carry.
// Assumes: NAMT_W can hold the value DATA_W.
module bsh_amount_decode #(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int SH_W     = $clog2(DATA_W),
    localparam int NAMT_W   = (REG_AMT_W > SH_W) ? REG_AMT_W : SH_W + 1
) (
    input  logic                 use_reg,
    input  bsh_pkg::shift_kind_e kind,
    input  logic [SH_W-1:0]      imm_amt,
    input  logic [REG_AMT_W-1:0] reg_amt,
    output logic [NAMT_W-1:0]    amt,
    output logic                 pass_thru,
    output logic                 rrx
);
    import bsh_pkg::*;

    // Decode: pick the amount source, then apply the zero-amount meanings.
    always_comb begin
        amt       = '0;
        pass_thru = 1'b0;
        rrx       = 1'b0;
        if (use_reg) begin
            amt       = NAMT_W'(reg_amt);
            pass_thru = (reg_amt == '0);
        end else if (imm_amt != '0) begin
            amt = NAMT_W'(imm_amt);
        end else begin
            unique case (kind)
                SH_LSL:  pass_thru = 1'b1;
                SH_LSR:  amt = NAMT_W'(DATA_W);
                SH_ASR:  amt = NAMT_W'(DATA_W);
                SH_ROR:  rrx = 1'b1;
                default: pass_thru = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/bsh_shift_core.sv
// Module: shift core for nonzero effective amounts.
// Produces the result and the last-bit-out carry for the four shift kinds,
// including amounts of DATA_W and above.
// Assumes: amt is nonzero; zero is handled by the caller.
module bsh_shift_core #(
    parameter int DATA_W = 32,
    parameter int NAMT_W = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]    opnd,
    input  bsh_pkg::shift_kind_e kind,
    input  logic [NAMT_W-1:0]    amt,
    output logic [DATA_W-1:0]    res,
    output logic                 cout
);
    import bsh_pkg::*;

    logic [DATA_W:0]   lsl_ext;
    logic [DATA_W:0]   lsr_ext;
    logic [DATA_W:0]   asr_ext;
    logic [DATA_W-1:0] ror_q;

    // Each extended vector carries one extra bit that catches the last bit out.
    assign lsl_ext = {1'b0, opnd} << amt;
    assign lsr_ext = {opnd, 1'b0} >> amt;
    assign asr_ext = $unsigned($signed({opnd, 1'b0}) >>> amt);

    // Rotate uses the amount modulo DATA_W.
    bsh_rotator #(.W(DATA_W)) u_ror (
        .d   (opnd),
        .amt (amt[SH_W-1:0]),
        .q   (ror_q)
    );

    // Select: route the chosen kind to the outputs.
    always_comb begin
        unique case (kind)
            SH_LSL: begin
                res  = lsl_ext[DATA_W-1:0];
                cout = lsl_ext[DATA_W];
            end
            SH_LSR: begin
                res  = lsr_ext[DATA_W:1];
                cout = lsr_ext[0];
            end
            SH_ASR: begin
                res  = asr_ext[DATA_W:1];
                cout = asr_ext[0];
            end
            default: begin
                res  = ror_q;
                cout = ror_q[DATA_W-1];
            end
        endcase
    end

endmodule

// File: rtl/bsh_rot_imm.sv
// Module: rotated-immediate generator.
// Zero-extends an immediate and rotates it right by twice the rotate field.
// The carry is result bit 31 for a nonzero rotation, else the incoming carry.
// Assumes: 2*(2**ROT_W - 1) < DATA_W.
module bsh_rot_imm #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    logic [SH_W-1:0] rot_amt;

    assign rot_amt = SH_W'({rot, 1'b0});

    bsh_rotator #(.W(DATA_W)) u_rot (
        .d   (DATA_W'(imm)),
        .amt (rot_amt),
        .q   (res)
    );

    // Carry: take the top result bit only when the rotation is nonzero.
    always_comb begin
        cout = (rot != '0) ? res[DATA_W-1] : cin;
    end

endmodule

// File: rtl/bsh_operand_shifter.sv
// Module: operand barrel shifter with carry-out (top).
// Builds the second ALU operand from a shifted register or a rotated
// immediate, and returns the shifter carry for logical operations.
// Assumes: purely combinational; no clock or reset.
module bsh_operand_shifter #(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4,
    localparam int SH_W     = $clog2(DATA_W),
    localparam int NAMT_W   = (REG_AMT_W > SH_W) ? REG_AMT_W : SH_W + 1
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        kind_i,
    input  logic [1:0]        form_i,
    input  logic [SH_W-1:0]   imm_amt_i,
    input  logic [DATA_W-1:0] reg_amt_i,
    input  logic [ROT_W-1:0]  rot_i,
    input  logic [IMM_W-1:0]  imm8_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    import bsh_pkg::*;

    shift_kind_e       kind;
    logic              is_rot_imm;
    logic              use_reg;
    logic [NAMT_W-1:0] amt;
    logic              pass_thru;
    logic              rrx;
    logic [DATA_W-1:0] core_res;
    logic              core_c;
    logic [DATA_W-1:0] imm_res;
    logic              imm_c;

    assign kind       = shift_kind_e'(kind_i);
    assign is_rot_imm = form_i[1];
    assign use_reg    = (form_i == FORM_REG_AMT);

    bsh_amount_decode #(
        .DATA_W    (DATA_W),
        .REG_AMT_W (REG_AMT_W)
    ) u_amt (
        .use_reg   (use_reg),
        .kind      (kind),
        .imm_amt   (imm_amt_i),
        .reg_amt   (reg_amt_i[REG_AMT_W-1:0]),
        .amt       (amt),
        .pass_thru (pass_thru),
        .rrx       (rrx)
    );

    bsh_shift_core #(
        .DATA_W (DATA_W),
        .NAMT_W (NAMT_W)
    ) u_core (
        .opnd (opnd_i),
        .kind (kind),
        .amt  (amt),
        .res  (core_res),
        .cout (core_c)
    );

    bsh_rot_imm #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_imm (
        .imm  (imm8_i),
        .rot  (rot_i),
        .cin  (carry_i),
        .res  (imm_res),
        .cout (imm_c)
    );

    // Output select: rotated immediate, pass-through, rotate-through-carry, or core.
    always_comb begin
        if (is_rot_imm) begin
            result_o = imm_res;
            carry_o  = imm_c;
        end else if (pass_thru) begin
            result_o = opnd_i;
            carry_o  = carry_i;
        end else if (rrx) begin
            result_o = {carry_i, opnd_i[DATA_W-1:1]};
            carry_o  = opnd_i[0];
        end else begin
            result_o = core_res;
            carry_o  = core_c;
        end
    end

endmodule

// File: rtl/bsh_operand_shifter_chk.sv
// Module: port-level checker for the operand shifter, bound to the top.
// Assumes: combinational target, so immediate assertions on settled values.
module bsh_operand_shifter_chk #(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int IMM_W     = 8,
    parameter int ROT_W     = 4,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] opnd_i,
    input logic [1:0]        kind_i,
    input logic [1:0]        form_i,
    input logic [SH_W-1:0]   imm_amt_i,
    input logic [DATA_W-1:0] reg_amt_i,
    input logic [ROT_W-1:0]  rot_i,
    input logic [IMM_W-1:0]  imm8_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o
);

    logic [REG_AMT_W-1:0] ramt;
    logic                 sgn;

    assign ramt = reg_amt_i[REG_AMT_W-1:0];
    assign sgn  = opnd_i[DATA_W-1];

    // Checks: special-case results seen at the ports.
    always_comb begin
        if (form_i == 2'd0 && imm_amt_i == '0) begin
            // R2
            lsl_zero_pass_chk: assert (kind_i != 2'd0 || (result_o == opnd_i && carry_o == carry_i));
            // R3
            lsr_imm32_chk: assert (kind_i != 2'd1 || (result_o == '0 && carry_o == sgn));
            // R4
            asr_imm32_chk: assert (kind_i != 2'd2 || (result_o == {DATA_W{sgn}} && carry_o == sgn));
            // R5
            rrx_chk: assert (kind_i != 2'd3 ||
                             (result_o == {carry_i, opnd_i[DATA_W-1:1]} && carry_o == opnd_i[0]));
        end
        if (form_i == 2'd1) begin
            // R6
            reg_zero_pass_chk: assert (ramt != '0 || (result_o == opnd_i && carry_o == carry_i));
            // R7
            lsl_over_chk: assert (!(kind_i == 2'd0 && ramt > REG_AMT_W'(DATA_W)) ||
                                  (result_o == '0 && carry_o == 1'b0));
            // R8
            lsr_over_chk: assert (!(kind_i == 2'd1 && ramt > REG_AMT_W'(DATA_W)) ||
                                  (result_o == '0 && carry_o == 1'b0));
            // R9
            asr_over_chk: assert (!(kind_i == 2'd2 && ramt >= REG_AMT_W'(DATA_W)) ||
                                  (result_o == {DATA_W{sgn}} && carry_o == sgn));
            // R10
            ror_mult_chk: assert (!(kind_i == 2'd3 && ramt != '0 && ramt[SH_W-1:0] == '0) ||
                                  (result_o == opnd_i && carry_o == sgn));
        end
        if (form_i[1]) begin
            // R11
            rot_imm_zero_chk: assert (rot_i != '0 ||
                                      (result_o == DATA_W'(imm8_i) && carry_o == carry_i));
            // R11
            rot_imm_carry_chk: assert (rot_i == '0 || carry_o == result_o[DATA_W-1]);
            // R11
            rot_imm_pop_chk: assert ($countones(result_o) == $countones(imm8_i));
        end
    end

endmodule

bind bsh_operand_shifter bsh_operand_shifter_chk #(
    .DATA_W    (DATA_W),
    .REG_AMT_W (REG_AMT_W),
    .IMM_W     (IMM_W),
    .ROT_W     (ROT_W)
) u_chk (
    .opnd_i    (opnd_i),
    .kind_i    (kind_i),
    .form_i    (form_i),
    .imm_amt_i (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .rot_i     (rot_i),
    .imm8_i    (imm8_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
);

// File: tb/bsh_operand_shifter_tb.sv
// Bench: vector table walk, then directed sweeps and unused-input tests.
module bsh_operand_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_i = '0;
    logic [1:0]  kind_i = '0;
    logic [1:0]  form_i = '0;
    logic [4:0]  imm_amt_i = '0;
    logic [31:0] reg_amt_i = '0;
    logic [3:0]  rot_i = '0;
    logic [7:0]  imm8_i = '0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bsh_operand_shifter dut_i (
        .opnd_i    (opnd_i),
        .kind_i    (kind_i),
        .form_i    (form_i),
        .imm_amt_i (imm_amt_i),
        .reg_amt_i (reg_amt_i),
        .rot_i     (rot_i),
        .imm8_i    (imm8_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    typedef struct packed {
        logic [1:0]  form;
        logic [1:0]  kind;
        logic [4:0]  amt;
        logic [31:0] ramt;
        logic [3:0]  rot;
        logic [7:0]  imm8;
        logic        cin;
        logic [31:0] opnd;
        logic [31:0] eres;
        logic        ec;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] A = 32'h9000_0005;
    localparam int NVEC = 32;
    localparam vec_t VECS [NVEC] = '{
        // R1 immediate shifts, amounts 1..31
        '{2'd0, 2'd0, 5'd4,  32'hFFFF_FFFF, 4'd7,  8'hAA, 1'b0, A, 32'h0000_0050, 1'b1, 8'd1},
        '{2'd0, 2'd1, 5'd1,  32'h0000_0000, 4'd3,  8'h11, 1'b0, A, 32'h4800_0002, 1'b1, 8'd1},
        '{2'd0, 2'd2, 5'd4,  32'h0000_0003, 4'd1,  8'h22, 1'b1, A, 32'hF900_0000, 1'b0, 8'd1},
        '{2'd0, 2'd3, 5'd8,  32'h0000_0010, 4'd2,  8'h33, 1'b1, A, 32'h0590_0000, 1'b0, 8'd1},
        // R2 left shift by zero
        '{2'd0, 2'd0, 5'd0,  32'h0000_0004, 4'd5,  8'h44, 1'b1, A, A,             1'b1, 8'd2},
        '{2'd0, 2'd0, 5'd0,  32'h0000_0004, 4'd5,  8'h44, 1'b0, A, A,             1'b0, 8'd2},
        // R3 logical right zero means 32
        '{2'd0, 2'd1, 5'd0,  32'h0000_0001, 4'd0,  8'h00, 1'b0, A, 32'h0,         1'b1, 8'd3},
        '{2'd0, 2'd1, 5'd0,  32'h0000_0001, 4'd0,  8'h00, 1'b1, 32'h7FFF_FFFF, 32'h0, 1'b0, 8'd3},
        // R4 arithmetic right zero means 32
        '{2'd0, 2'd2, 5'd0,  32'h0000_0001, 4'd0,  8'h00, 1'b0, A, 32'hFFFF_FFFF, 1'b1, 8'd4},
        '{2'd0, 2'd2, 5'd0,  32'h0000_0001, 4'd0,  8'h00, 1'b1, 32'h7000_0000, 32'h0, 1'b0, 8'd4},
        // R5 rotate through carry
        '{2'd0, 2'd3, 5'd0,  32'h0000_0000, 4'd0,  8'h00, 1'b1, A, 32'hC800_0002, 1'b1, 8'd5},
        '{2'd0, 2'd3, 5'd0,  32'h0000_0000, 4'd0,  8'h00, 1'b0, 32'h2, 32'h1,     1'b0, 8'd5},
        // R6 register amount, low 8 bits only
        '{2'd1, 2'd1, 5'd9,  32'h0000_0100, 4'd0,  8'h00, 1'b1, A, A,             1'b1, 8'd6},
        '{2'd1, 2'd3, 5'd0,  32'h0000_FF00, 4'd0,  8'h00, 1'b0, A, A,             1'b0, 8'd6},
        '{2'd1, 2'd0, 5'd0,  32'hFFFF_FF01, 4'd0,  8'h00, 1'b0, A, 32'h2000_000A, 1'b1, 8'd6},
        // R7 left by 32 and above
        '{2'd1, 2'd0, 5'd0,  32'd32,        4'd0,  8'h00, 1'b0, A, 32'h0,         1'b1, 8'd7},
        '{2'd1, 2'd0, 5'd0,  32'd33,        4'd0,  8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd7},
        // R8 logical right by 32 and above
        '{2'd1, 2'd1, 5'd0,  32'd32,        4'd0,  8'h00, 1'b0, A, 32'h0,         1'b1, 8'd8},
        '{2'd1, 2'd1, 5'd0,  32'd40,        4'd0,  8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'd8},
        // R9 arithmetic right by 32 and above
        '{2'd1, 2'd2, 5'd0,  32'd32,        4'd0,  8'h00, 1'b0, A, 32'hFFFF_FFFF, 1'b1, 8'd9},
        '{2'd1, 2'd2, 5'd0,  32'd200,       4'd0,  8'h00, 1'b1, 32'h7FFF_FFFF, 32'h0, 1'b0, 8'd9},
        // R10 register rotate modulo 32
        '{2'd1, 2'd3, 5'd0,  32'd36,        4'd0,  8'h00, 1'b1, A, 32'h5900_0000, 1'b0, 8'd10},
        '{2'd1, 2'd3, 5'd0,  32'd64,        4'd0,  8'h00, 1'b0, A, A,             1'b1, 8'd10},
        '{2'd1, 2'd3, 5'd0,  32'd32,        4'd0,  8'h00, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 8'd10},
        // R11 rotated immediate, forms 2 and 3
        '{2'd2, 2'd0, 5'd3,  32'h0000_0005, 4'd4,  8'hFF, 1'b0, A, 32'hFF00_0000, 1'b1, 8'd11},
        '{2'd2, 2'd1, 5'd0,  32'h0000_0000, 4'd0,  8'h80, 1'b1, A, 32'h0000_0080, 1'b1, 8'd11},
        '{2'd2, 2'd2, 5'd7,  32'h0000_0021, 4'd1,  8'h03, 1'b0, A, 32'hC000_0000, 1'b1, 8'd11},
        '{2'd2, 2'd3, 5'd0,  32'h0000_0040, 4'd15, 8'h81, 1'b1, A, 32'h0000_0204, 1'b0, 8'd11},
        '{2'd3, 2'd0, 5'd1,  32'h0000_0000, 4'd4,  8'hFF, 1'b0, A, 32'hFF00_0000, 1'b1, 8'd11},
        '{2'd3, 2'd1, 5'd0,  32'h0000_0000, 4'd0,  8'h5A, 1'b0, A, 32'h0000_005A, 1'b0, 8'd11},
        // R6 register left by 31 with high garbage; R1 immediate right by 31
        '{2'd1, 2'd0, 5'd2,  32'hAB00_001F, 4'd0,  8'h00, 1'b1, A, 32'h8000_0000, 1'b0, 8'd6},
        '{2'd0, 2'd1, 5'd31, 32'h0000_0000, 4'd0,  8'h00, 1'b1, A, 32'h0000_0001, 1'b0, 8'd1}
    };

    task automatic check(input string tag, input logic [31:0] eres, input logic ec);
        checks++;
        if (result_o !== eres || carry_o !== ec) begin
            fails++;
            $display("FAIL %s: actual result=%h carry=%b expected result=%h carry=%b",
                     tag, result_o, carry_o, eres, ec);
        end
    endtask

    task automatic apply(input logic [1:0] f, input logic [1:0] k, input logic [4:0] a,
                         input logic [31:0] ra, input logic [3:0] r, input logic [7:0] i8,
                         input logic c, input logic [31:0] op);
        @(posedge clk);
        form_i = f; kind_i = k; imm_amt_i = a; reg_amt_i = ra;
        rot_i = r; imm8_i = i8; carry_i = c; opnd_i = op;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] x;
        x = 32'hA5C3_0F96;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset: all-zero inputs give zero result and carry
        check("R1 reset-state zero inputs", 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            apply(VECS[v].form, VECS[v].kind, VECS[v].amt, VECS[v].ramt,
                  VECS[v].rot, VECS[v].imm8, VECS[v].cin, VECS[v].opnd);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), VECS[v].eres, VECS[v].ec);
        end

        // R1 sweep: immediate left and logical right for every amount 1..31
        for (int n = 1; n < 32; n++) begin
            apply(2'd0, 2'd0, 5'(n), 32'h0, 4'd0, 8'h0, 1'b0, x);
            check($sformatf("R1 lsl n=%0d", n), x * (32'd1 << n), x[32-n]);
            apply(2'd0, 2'd1, 5'(n), 32'h0, 4'd0, 8'h0, 1'b1, x);
            check($sformatf("R1 lsr n=%0d", n), x / (32'd1 << n), x[n-1]);
        end

        // R9 sweep: register arithmetic right from 32 to 255 on a negative operand
        for (int n = 32; n < 256; n += 17) begin
            apply(2'd1, 2'd2, 5'd0, 32'(n), 4'd0, 8'h0, 1'b0, x);
            check($sformatf("R9 asr n=%0d", n), 32'hFFFF_FFFF, 1'b1);
        end

        // R12 form 0 ignores reg amount, rotate field and immediate
        apply(2'd0, 2'd0, 5'd4, 32'h0000_0000, 4'd0, 8'h00, 1'b0, A);
        check("R12 form0 baseline", 32'h0000_0050, 1'b1);
        apply(2'd0, 2'd0, 5'd4, 32'h0000_0001, 4'd9, 8'h7E, 1'b0, A);
        check("R12 form0 unused inputs changed", 32'h0000_0050, 1'b1);
        // R12 form 1 ignores the immediate amount, rotate field and immediate
        apply(2'd1, 2'd1, 5'd31, 32'd1, 4'd0, 8'h00, 1'b0, A);
        check("R12 form1 amt=31 ignored", 32'h4800_0002, 1'b1);
        apply(2'd1, 2'd1, 5'd0, 32'd1, 4'd15, 8'hFF, 1'b0, A);
        check("R12 form1 amt=0 ignored", 32'h4800_0002, 1'b1);
        // R12 rotated immediate ignores operand, kind and both amounts
        apply(2'd2, 2'd3, 5'd0, 32'd0, 4'd4, 8'hFF, 1'b0, 32'h0);
        check("R12 rotimm zeros elsewhere", 32'hFF00_0000, 1'b1);
        apply(2'd2, 2'd0, 5'd17, 32'd255, 4'd4, 8'hFF, 1'b0, 32'hFFFF_FFFF);
        check("R12 rotimm garbage elsewhere", 32'hFF00_0000, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule